// File: doc/BRIEF.md
# Clock-Multiplier Setup Register Controller

This block holds one CPU-writable setup register for a network controller. The register carries a fast-read timing enable, a two-bit clock-multiplier select, an enhanced-functions enable and a bit that lifts the idle-line condition on RAM initialization. It also controls the network core around a change of clock rate. The first legal change of the multiplier select after reset powers up the external PLL and stops the core. The core stays stopped until software writes the restart command code to the command register and the PLL reports lock. Every later attempt to change the select is dropped until the next reset.

Around the register, the block forms two gates. The first enables fast read timing only when the external bus-timing pin is also high. The second lets a RAM initialization request through only when the line is idle or the no-sync bit is set. The block also keeps a sticky error flag. The flag is raised when the fastest clock setting is held without the enhanced-functions bit, because that bit is required above 5 Mbps.

Top module: `clkmul_setup_ctrl`

## Requirements
- R1: After reset, cfg_rdata reads 0x00, mul_sel is 00, pll_enable is 0, core_run is 1 and cfg_err is 0.
- R2: The register layout is as follows. Bit 7 is fast-read enable, bits 5:4 are the multiplier select, bit 3 is enhanced functions, bit 2 is no-sync and bit 0 is the read-only error flag. Bits 6 and 1 read 0, and writes to bits 6, 1 and 0 have no effect.
- R3: The multiplier codes are 00 = 20 MHz (reset default), 01 = 40 MHz and 11 = 80 MHz. A write of 01 or 11 that differs from the current code, made while the allowance is unused, takes effect at the write edge. From that edge on, pll_enable is 1 and core_run is 0. pll_enable is 0 only while the select is still at its reset value.
- R4: After one accepted change, any write to bits 5:4 leaves mul_sel unchanged until reset, while the other fields of the same write still update. Reset restores the allowance.
- R5: A write of the reserved code 10 leaves mul_sel unchanged and does not use up the allowance.
- R6: After a change, core_run stays 0 until the command 0x18 is written. Other command values have no effect. After the restart command, core_run equals pll_lock.
- R7: fast_read_en is 1 exactly when bus_timing_pin is 1 and register bit 7 is 1.
- R8: init_accept is 1 exactly when init_req is 1 and either line_idle or register bit 2 is 1.
- R9: One cycle after mul_sel is 11 while bit 3 is 0, cfg_err becomes 1. It then stays 1, and reads as bit 0, until reset.
- R10: A write whose select equals the current code is not a change. It does not stop the core and does not use up the allowance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cfg_wr | input | 1 | Setup register write strobe |
| cfg_wdata | input | DATA_W | Setup register write data |
| cfg_rdata | output | DATA_W | Setup register read value |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | DATA_W | Command register write data |
| pll_lock | input | 1 | PLL lock indication |
| bus_timing_pin | input | 1 | External bus-timing strap |
| line_idle | input | 1 | Network line idle indication |
| init_req | input | 1 | RAM initialization sequence request |
| mul_sel | output | 2 | Active multiplier select |
| pll_enable | output | 1 | PLL power-up |
| core_run | output | 1 | Network core run enable |
| fast_read_en | output | 1 | Fast CPU read timing active |
| init_accept | output | 1 | RAM initialization accepted |
| cfg_err | output | 1 | Sticky rate/enhanced-function mismatch |

## Verification
On every cycle the assertions check the following. The select never holds the reserved code or changes more than once per reset. A change always coincides with a stopped core and a powered PLL. A running core on the PLL clock implies lock. The error flag never clears. Both output gates never open without their enabling inputs. Only the bench's scenarios can show the rest: the exact command code that releases the core, that other command values are ignored, that reserved and repeated codes leave the allowance intact, and that the other fields still update when a select change is refused.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;

   localparam int unsigned FAST_BIT   = 7;
   localparam int unsigned MUL_LSB    = 4;
   localparam int unsigned EF_BIT     = 3;
   localparam int unsigned NOSYNC_BIT = 2;
   localparam int unsigned ERR_BIT    = 0;
   localparam int unsigned MUL_W      = 2;
   localparam int unsigned MIN_W      = FAST_BIT + 1;

   typedef enum logic [MUL_W-1:0] {
      MUL_X1   = 2'b00,
      MUL_X2   = 2'b01,
      MUL_RSVD = 2'b10,
      MUL_X4   = 2'b11
   } mul_code_e;

   typedef struct packed {
      logic fast_rd;
      logic ef;
      logic nosync;
   } setup_fields_t;

   function automatic logic code_usable(mul_code_e c);
      return c != MUL_RSVD;
   endfunction

endpackage

// File: rtl/clkmul_field_regs.sv
module clkmul_field_regs
   import clkmul_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output setup_fields_t     fields
);

   if (DATA_W < MIN_W) begin : g_width_check
      $error("clkmul_field_regs: DATA_W too narrow for field layout");
   end

   setup_fields_t next_fields;

   always_comb begin
      next_fields         = fields;
      if (wr) begin
         next_fields.fast_rd = wdata[FAST_BIT];
         next_fields.ef      = wdata[EF_BIT];
         next_fields.nosync  = wdata[NOSYNC_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fields <= '0;
      end else begin
         fields <= next_fields;
      end
   end

endmodule

// File: rtl/clkmul_rate_seq.sv
module clkmul_rate_seq
   import clkmul_pkg::*;
#(
   parameter int unsigned     DATA_W      = 8,
   parameter logic [DATA_W-1:0] RESTART_CMD = 8'h18,
   parameter bit              ONCE_LOCK   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_wr,
   input  mul_code_e         sel_new,
   input  logic              cmd_wr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              pll_lock,
   output mul_code_e         mul_cur,
   output logic              pll_en,
   output logic              core_run
);

   logic allow;
   logic halted;
   logic take_new;
   logic restart_hit;

   assign take_new    = sel_wr && code_usable(sel_new) && (sel_new != mul_cur) && allow;
   assign restart_hit = cmd_wr && (cmd_data == RESTART_CMD) && halted;

   if (ONCE_LOCK) begin : g_once
      logic allow_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            allow_q <= 1'b1;
         end else if (take_new) begin
            allow_q <= 1'b0;
         end
      end
      assign allow = allow_q;
   end else begin : g_free
      assign allow = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mul_cur <= MUL_X1;
         pll_en  <= 1'b0;
         halted  <= 1'b0;
      end else if (take_new) begin
         mul_cur <= sel_new;
         pll_en  <= 1'b1;
         halted  <= 1'b1;
      end else if (restart_hit) begin
         halted  <= 1'b0;
      end
   end

   assign core_run = !halted && (!pll_en || pll_lock);

endmodule

// File: rtl/clkmul_cfg_guard.sv
module clkmul_cfg_guard
   import clkmul_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  mul_code_e mul_cur,
   input  logic      ef,
   output logic      err
);

   logic mismatch;

   assign mismatch = (mul_cur == MUL_X4) && !ef;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err <= 1'b0;
      end else if (mismatch) begin
         err <= 1'b1;
      end
   end

endmodule

// File: rtl/clkmul_setup_ctrl.sv
module clkmul_setup_ctrl
   import clkmul_pkg::*;
#(
   parameter int unsigned       DATA_W      = 8,
   parameter logic [DATA_W-1:0] RESTART_CMD = 8'h18,
   parameter bit                ONCE_LOCK   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              cmd_wr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              pll_lock,
   input  logic              bus_timing_pin,
   input  logic              line_idle,
   input  logic              init_req,
   output logic [1:0]        mul_sel,
   output logic              pll_enable,
   output logic              core_run,
   output logic              fast_read_en,
   output logic              init_accept,
   output logic              cfg_err
);

   if (DATA_W < MIN_W) begin : g_width_check
      $error("clkmul_setup_ctrl: DATA_W must hold the setup fields");
   end
   if (RESTART_CMD == '0) begin : g_cmd_check
      $error("clkmul_setup_ctrl: restart code must be non-zero");
   end

   setup_fields_t fields;
   mul_code_e     mul_cur;
   mul_code_e     sel_new;

   assign sel_new = mul_code_e'(cfg_wdata[MUL_LSB +: MUL_W]);

   clkmul_field_regs #(.DATA_W(DATA_W)) u_fields (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (cfg_wr),
      .wdata  (cfg_wdata),
      .fields (fields)
   );

   clkmul_rate_seq #(
      .DATA_W      (DATA_W),
      .RESTART_CMD (RESTART_CMD),
      .ONCE_LOCK   (ONCE_LOCK)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_wr   (cfg_wr),
      .sel_new  (sel_new),
      .cmd_wr   (cmd_wr),
      .cmd_data (cmd_wdata),
      .pll_lock (pll_lock),
      .mul_cur  (mul_cur),
      .pll_en   (pll_enable),
      .core_run (core_run)
   );

   clkmul_cfg_guard u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .mul_cur (mul_cur),
      .ef      (fields.ef),
      .err     (cfg_err)
   );

   always_comb begin
      cfg_rdata                      = '0;
      cfg_rdata[FAST_BIT]            = fields.fast_rd;
      cfg_rdata[MUL_LSB +: MUL_W]    = mul_cur;
      cfg_rdata[EF_BIT]              = fields.ef;
      cfg_rdata[NOSYNC_BIT]          = fields.nosync;
      cfg_rdata[ERR_BIT]             = cfg_err;
   end

   assign mul_sel      = mul_cur;
   assign fast_read_en = bus_timing_pin && fields.fast_rd;
   assign init_accept  = init_req && (line_idle || fields.nosync);

endmodule

// File: rtl/clkmul_setup_ctrl_chk.sv
module clkmul_setup_ctrl_chk
   import clkmul_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter bit          ONCE_LOCK = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pll_lock,
   input logic              bus_timing_pin,
   input logic              line_idle,
   input logic              init_req,
   input logic [DATA_W-1:0] cfg_rdata,
   input logic [1:0]        mul_sel,
   input logic              pll_enable,
   input logic              core_run,
   input logic              fast_read_en,
   input logic              init_accept,
   input logic              cfg_err
);

   logic [1:0] prev_mul;
   logic [1:0] chg_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_mul <= 2'b00;
         chg_cnt  <= 2'd0;
      end else begin
         prev_mul <= mul_sel;
         if (mul_sel != prev_mul && chg_cnt != 2'd3) chg_cnt <= chg_cnt + 2'd1;
      end
   end

   a_r3_halt_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_sel != prev_mul) |-> (!core_run && pll_enable));

   a_r3_pll_off_only_default: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_enable |-> (mul_sel == 2'b00));

   a_r4_single_change: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_cnt <= 2'd1) || !ONCE_LOCK);

   a_r5_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      mul_sel != 2'b10);

   a_r6_run_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (core_run && pll_enable) |-> pll_lock);

   a_r7_fast_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
      fast_read_en |-> (bus_timing_pin && cfg_rdata[FAST_BIT]));

   a_r8_init_gate: assert property (@(posedge clk) disable iff (!rst_n)
      init_accept |-> (init_req && (line_idle || cfg_rdata[NOSYNC_BIT])));

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);

endmodule

bind clkmul_setup_ctrl clkmul_setup_ctrl_chk #(.DATA_W(DATA_W), .ONCE_LOCK(ONCE_LOCK)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .pll_lock       (pll_lock),
   .bus_timing_pin (bus_timing_pin),
   .line_idle      (line_idle),
   .init_req       (init_req),
   .cfg_rdata      (cfg_rdata),
   .mul_sel        (mul_sel),
   .pll_enable     (pll_enable),
   .core_run       (core_run),
   .fast_read_en   (fast_read_en),
   .init_accept    (init_accept),
   .cfg_err        (cfg_err)
);

// File: tb/tb_clkmul_setup_ctrl.sv
module tb_clkmul_setup_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 8;

   // {pin, rd_bit, nosync, idle, req, exp_fast, exp_accept}
   localparam logic [6:0] VEC [NVEC] = '{
      7'b11011_11, 7'b10011_01, 7'b01001_00, 7'b00101_01,
      7'b11100_10, 7'b01111_01, 7'b11001_10, 7'b00010_00
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       cmd_wr = 1'b0;
   logic [7:0] cmd_wdata = '0;
   logic       pll_lock = 1'b0;
   logic       bus_timing_pin = 1'b0;
   logic       line_idle = 1'b0;
   logic       init_req = 1'b0;
   logic [1:0] mul_sel;
   logic       pll_enable, core_run, fast_read_en, init_accept, cfg_err;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   clkmul_setup_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .pll_lock(pll_lock), .bus_timing_pin(bus_timing_pin),
      .line_idle(line_idle), .init_req(init_req), .mul_sel(mul_sel),
      .pll_enable(pll_enable), .core_run(core_run),
      .fast_read_en(fast_read_en), .init_accept(init_accept), .cfg_err(cfg_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cfg_write(input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cmd_write(input logic [7:0] d);
      @(negedge clk);
      cmd_wr = 1'b1;
      cmd_wdata = d;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      check("R1 rdata", cfg_rdata, 8'h00);
      check("R1 mul_sel", mul_sel, 2'b00);
      check("R1 pll_enable", pll_enable, 1'b0);
      check("R1 core_run", core_run, 1'b1);
      check("R1 cfg_err", cfg_err, 1'b0);

      // R2 reserved bits and read-only error bit
      cfg_write(8'hC7);
      check("R2 layout", cfg_rdata, 8'h84);
      check("R10 same code no halt", core_run, 1'b1);

      // R7 / R8 vector walk
      for (int i = 0; i < NVEC; i++) begin
         cfg_write({VEC[i][5], 4'b0000, VEC[i][4], 2'b00});
         bus_timing_pin = VEC[i][6];
         line_idle      = VEC[i][3];
         init_req       = VEC[i][2];
         #1;
         check("R7 fast_read_en", fast_read_en, VEC[i][1]);
         check("R8 init_accept", init_accept, VEC[i][0]);
      end
      bus_timing_pin = 1'b0;
      init_req = 1'b0;

      // R5 reserved code ignored
      cfg_write(8'h20);
      check("R5 rsvd mul", mul_sel, 2'b00);
      check("R5 rsvd pll", pll_enable, 1'b0);

      // R3 first legal change (allowance survived R5)
      cfg_write(8'h38);
      check("R3 rdata", cfg_rdata, 8'h38);
      check("R3 pll_enable", pll_enable, 1'b1);
      check("R3 core halted", core_run, 1'b0);

      // R6 restart sequencing
      @(negedge clk);
      pll_lock = 1'b1;
      #1;
      check("R6 lock alone", core_run, 1'b0);
      cmd_write(8'h17);
      check("R6 wrong cmd", core_run, 1'b0);
      cmd_write(8'h18);
      check("R6 restart", core_run, 1'b1);
      pll_lock = 1'b0;
      #1;
      check("R6 lock lost", core_run, 1'b0);
      pll_lock = 1'b1;
      #1;
      check("R6 lock back", core_run, 1'b1);

      // R4 second change ignored, other fields update; R9 error
      cfg_write(8'h10);
      check("R4 mul kept", cfg_rdata, 8'h30);
      check("R4 no halt", core_run, 1'b1);
      @(negedge clk);
      check("R9 err set", cfg_err, 1'b1);
      check("R9 err read", cfg_rdata, 8'h31);
      cfg_write(8'h38);
      check("R9 err sticky", cfg_rdata, 8'h39);

      do_reset();
      check("R9 err cleared", cfg_err, 1'b0);
      check("R4 reset rdata", cfg_rdata, 8'h00);

      // R10 same code keeps allowance; R4 allowance restored by reset
      cfg_write(8'h00);
      check("R10 no pll", pll_enable, 1'b0);
      cfg_write(8'h10);
      check("R10 change later", mul_sel, 2'b01);
      check("R3 halt 40", core_run, 1'b0);
      cfg_write(8'h30);
      check("R4 locked", mul_sel, 2'b01);
      @(negedge clk);
      check("R9 no err at 40", cfg_err, 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule